// File: doc/BRIEF.md
# SPI Master with Continuous Receive-Only Mode

This block is an SPI master (mode 0, MSB first) that moves words between a transmit FIFO, the serial pins and a receive FIFO. In its normal mode it starts a transfer whenever the transmit FIFO holds data. Each popped word is shifted out on MOSI while a word is shifted in from MISO, and the received word goes into the receive FIFO. The master stops once the transmit FIFO is empty.

Setting the receive-only control bit (with the enable bit) puts the master into a streaming receive mode. On entry both FIFOs and the overrun flag are cleared automatically. After a fixed start-up delay the serial clock runs without stopping, and every completed word is stored in the receive FIFO. Any word the user pushes into the transmit FIFO is still sent on MOSI; when none is waiting, MOSI carries zeros. Clearing the bit lets the current word finish before the clock parks low.

SCLK comes from the core clock through a programmable divider. The slave select can follow the engine's activity automatically or be driven by a control bit.

Top module: `spi_rxo_master`

## Requirements
- R1: After reset, spi_sclk is 0, spi_ss_n is 1, busy is 0, overrun is 0, and both FIFOs report empty.
- R2: SCLK idles low. Each SCLK level lasts ctl_div+1 core clock cycles, so one SCLK period is 2*(ctl_div+1) cycles, with a minimum of 2.
- R3: In normal mode (ctl_enable=1, ctl_rxonly=0), each word popped from the transmit FIFO is shifted out MSB first on spi_mosi, which changes after falling SCLK edges. spi_miso is sampled on rising edges and the received word (first bit in the MSB) is pushed into the receive FIFO. The engine stops when the transmit FIFO is empty.
- R4: In receive-only mode, SCLK runs without gaps, including across word boundaries, for as long as the mode stays set.
- R5: The first clock edge that samples ctl_enable=1 and ctl_rxonly=1 while idle is the entry edge. At the edge after it, both FIFOs are emptied and overrun is cleared. Data pushed before entry is never sent.
- R6: If the entry edge is edge k, spi_sclk first goes high at edge k+6 (START_DLY=6) and stays low from edge k through edge k+5.
- R7: busy is 1 from the entry edge until the engine stops. With ctl_autoss=1, spi_ss_n is low whenever busy is 1; with ctl_autoss=0, spi_ss_n equals the inverse of ctl_ss.
- R8: In receive-only mode, a word pushed into the transmit FIFO after entry is sent on MOSI as the next word. A word that starts with the transmit FIFO empty is sent as all zeros.
- R9: A word that completes while the receive FIFO is full (and not being popped) is dropped and sets the sticky overrun flag. SCLK keeps running. Only a receive FIFO reset clears overrun.
- R10: A word that completes at the same edge as a pop of a full receive FIFO is stored, and overrun stays 0.
- R11: When receive-only mode is cleared, the word in progress completes. After that, SCLK stays low, busy falls and (with ctl_autoss=1) spi_ss_n rises.
- R12: A one-cycle pulse on ctl_txrst empties the transmit FIFO; a pulse on ctl_rxrst empties the receive FIFO and clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Master enable |
| ctl_rxonly | input | 1 | Receive-only streaming mode |
| ctl_autoss | input | 1 | Slave select follows engine activity |
| ctl_ss | input | 1 | Manual slave select level (1 = active) when ctl_autoss=0 |
| ctl_txrst | input | 1 | Transmit FIFO reset pulse |
| ctl_rxrst | input | 1 | Receive FIFO and overrun reset pulse |
| ctl_div | input | DIVW | SCLK half-period minus one, in core cycles |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | WORD_W | Word to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_data | output | WORD_W | Receive FIFO head word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| busy | output | 1 | Engine active (delay or shifting) |
| overrun | output | 1 | Sticky dropped-word flag |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |

## Verification
Two functions can fall in the same cycle: a word completing into a full receive FIFO, and a user pop of that FIFO. The bench derives the completion edge of the fifth streamed word from the entry edge and the divider setting, and asserts rx_pop for exactly that edge. It judges the outcome by overrun staying 0, the FIFO staying full, and the FIFO then holding words one to four in order. The next completion, with no pop, must set overrun while SCLK continues at its programmed period.

// File: rtl/spi_rxo_pkg.sv
package spi_rxo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_t;

  // Core cycles per full SCLK period for a divider setting.
  function automatic int unsigned sclk_period(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Core-cycle offset, from the entry edge, of the rising edge that samples
  // serial bit n in receive-only mode.
  function automatic int unsigned bit_rise_offset(input int unsigned start_dly,
                                                  input int unsigned div,
                                                  input int unsigned n);
    return start_dly + n * sclk_period(div);
  endfunction

endpackage

// File: rtl/spi_rxo_fifo.sv
module spi_rxo_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             push_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_idx, rd_idx;
  logic [CW-1:0]    count;
  logic             pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty && !flush;
  // A pop in the same cycle frees the slot a push needs.
  assign push_ok = push && !flush && (!full || pop_ok);
  assign dout    = mem[rd_idx];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] idx);
    return (idx == AW'(DEPTH - 1)) ? '0 : idx + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_idx <= bump(wr_idx);
      if (pop_ok)  rd_idx <= bump(rd_idx);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_rxo_divider.sv
module spi_rxo_divider #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [DIVW-1:0] div,
  output logic            half_done
);
  logic [DIVW-1:0] cnt;

  assign half_done = !hold && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (hold)      cnt <= '0;
    else if (half_done) cnt <= '0;
    else                cnt <= cnt + DIVW'(1);
  end
endmodule

// File: rtl/spi_rxo_engine.sv
module spi_rxo_engine
  import spi_rxo_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int START_DLY = 6   // at least 3, so the entry flush precedes the first load
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rxonly,
  input  logic              miso,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_dout,
  input  logic              half_done,
  output logic              div_hold,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              flush,
  output logic              entry,
  output logic              mode_rxo
);
  localparam int BCW = $clog2(WORD_W);
  localparam int DCW = $clog2(START_DLY + 1);

  eng_state_t        state;
  logic [DCW-1:0]    dcnt;
  logic [BCW-1:0]    bitcnt;
  logic [WORD_W-1:0] txsh, rxsh;

  logic req_rxo, start_norm, dly_load, dly_go;
  logic rise_evt, fall_evt, word_end, cont;
  logic [WORD_W-1:0] load_val;

  assign req_rxo    = en && rxonly;
  assign entry      = (state == ST_IDLE) && req_rxo;
  assign start_norm = (state == ST_IDLE) && en && !rxonly && !tx_empty;
  assign dly_load   = (state == ST_DELAY) && req_rxo && (dcnt == DCW'(1));
  assign dly_go     = (state == ST_DELAY) && req_rxo && (dcnt == '0);
  assign rise_evt   = (state == ST_RUN) && en && half_done && !sclk;
  assign fall_evt   = (state == ST_RUN) && en && half_done && sclk;
  assign word_end   = fall_evt && (bitcnt == '0);
  assign cont       = mode_rxo ? req_rxo : (en && !rxonly && !tx_empty);
  assign load_val   = tx_empty ? '0 : tx_dout;
  assign rx_word    = {rxsh[WORD_W-2:0], miso};

  assign tx_pop  = start_norm
                || (dly_load && !tx_empty)
                || (word_end && cont && !tx_empty);
  assign rx_push = rise_evt && (bitcnt == BCW'(WORD_W - 1));

  assign busy     = (state != ST_IDLE);
  assign div_hold = (state != ST_RUN);
  assign mosi     = busy ? txsh[WORD_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dcnt     <= '0;
      bitcnt   <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      sclk     <= 1'b0;
      flush    <= 1'b0;
      mode_rxo <= 1'b0;
    end else begin
      flush <= entry;
      unique case (state)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (entry) begin
            state    <= ST_DELAY;
            dcnt     <= DCW'(START_DLY - 1);
            mode_rxo <= 1'b1;
            txsh     <= '0;
            bitcnt   <= '0;
          end else if (start_norm) begin
            state    <= ST_RUN;
            mode_rxo <= 1'b0;
            txsh     <= tx_dout;
            bitcnt   <= '0;
          end
        end
        ST_DELAY: begin
          if (!req_rxo) begin
            state <= ST_IDLE;
          end else if (dly_go) begin
            state  <= ST_RUN;
            sclk   <= 1'b1;
            rxsh   <= rx_word;
            bitcnt <= BCW'(1);
          end else begin
            dcnt <= dcnt - DCW'(1);
            if (dly_load) txsh <= load_val;
          end
        end
        ST_RUN: begin
          if (!en) begin
            state <= ST_IDLE;
            sclk  <= 1'b0;
          end else if (rise_evt) begin
            sclk   <= 1'b1;
            rxsh   <= rx_word;
            bitcnt <= (bitcnt == BCW'(WORD_W - 1)) ? '0 : bitcnt + BCW'(1);
          end else if (fall_evt) begin
            sclk <= 1'b0;
            if (word_end) begin
              if (cont) txsh <= load_val;
              else      state <= ST_IDLE;
            end else begin
              txsh <= {txsh[WORD_W-2:0], 1'b0};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rxo_master.sv
module spi_rxo_master #(
  parameter int WORD_W    = 8,
  parameter int TX_DEPTH  = 4,
  parameter int RX_DEPTH  = 4,
  parameter int DIVW      = 8,
  parameter int START_DLY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_rxonly,
  input  logic              ctl_autoss,
  input  logic              ctl_ss,
  input  logic              ctl_txrst,
  input  logic              ctl_rxrst,
  input  logic [DIVW-1:0]   ctl_div,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              busy,
  output logic              overrun,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_ss_n
);
  // Internal events, named for the bound checker.
  logic              evt_entry, evt_word, evt_rx_acc, evt_mode_rxo;
  logic              eng_flush, div_hold, half_done, tx_pop, tx_acc_unused;
  logic              tx_flush, rx_flush;
  logic [WORD_W-1:0] tx_head, rx_word;

  assign tx_flush = ctl_txrst || eng_flush;
  assign rx_flush = ctl_rxrst || eng_flush;

  spi_rxo_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .din(tx_data), .pop(tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .push_ok(tx_acc_unused)
  );

  spi_rxo_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(evt_word), .din(rx_word), .pop(rx_pop), .dout(rx_data),
    .full(rx_full), .empty(rx_empty), .push_ok(evt_rx_acc)
  );

  spi_rxo_divider #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(div_hold), .div(ctl_div),
    .half_done(half_done)
  );

  spi_rxo_engine #(.WORD_W(WORD_W), .START_DLY(START_DLY)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctl_enable), .rxonly(ctl_rxonly),
    .miso(spi_miso), .tx_empty(tx_empty), .tx_dout(tx_head),
    .half_done(half_done), .div_hold(div_hold), .tx_pop(tx_pop),
    .rx_push(evt_word), .rx_word(rx_word), .sclk(spi_sclk),
    .mosi(spi_mosi), .busy(busy), .flush(eng_flush),
    .entry(evt_entry), .mode_rxo(evt_mode_rxo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         overrun <= 1'b0;
    else if (rx_flush)                  overrun <= 1'b0;
    else if (evt_word && !evt_rx_acc)   overrun <= 1'b1;
  end

  assign spi_ss_n = ctl_autoss ? !busy : !ctl_ss;
endmodule

// File: rtl/spi_rxo_checker.sv
module spi_rxo_checker #(
  parameter int START_DLY = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_enable,
  input logic ctl_rxonly,
  input logic ctl_autoss,
  input logic ctl_rxrst,
  input logic rx_pop,
  input logic busy,
  input logic spi_sclk,
  input logic spi_ss_n,
  input logic overrun,
  input logic rx_full,
  input logic rx_empty,
  input logic tx_empty,
  input logic evt_entry,
  input logic evt_word,
  input logic evt_rx_acc,
  input logic evt_mode_rxo
);
  logic [7:0] since;
  logic       req;

  assign req = ctl_enable && ctl_rxonly;

  // Cycles since the entry edge, used to check the start-up window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since <= '0;
    else if (evt_entry)                  since <= 8'd1;
    else if (!busy)                      since <= '0;
    else if (since != '0 && since <= 8'(START_DLY)) since <= since + 8'd1;
    else                                 since <= '0;
  end

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  assert_quiet_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since != '0 && since <= 8'(START_DLY) && busy) |-> !spi_sclk);

  assert_first_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 8'(START_DLY + 1) && busy) |-> spi_sclk);

  assert_entry_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_entry |=> ##1 (rx_empty && tx_empty));

  assert_busy_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(evt_mode_rxo) && $past(req) && req) |-> busy);

  assert_ss_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_autoss && busy) |-> !spi_ss_n);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_word && !evt_rx_acc && !ctl_rxrst) |=> overrun);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_word && rx_full && rx_pop && !ctl_rxrst) |-> evt_rx_acc);
endmodule

bind spi_rxo_master spi_rxo_checker #(.START_DLY(START_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_rxonly(ctl_rxonly),
  .ctl_autoss(ctl_autoss), .ctl_rxrst(ctl_rxrst), .rx_pop(rx_pop),
  .busy(busy), .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .overrun(overrun),
  .rx_full(rx_full), .rx_empty(rx_empty), .tx_empty(tx_empty),
  .evt_entry(evt_entry), .evt_word(evt_word), .evt_rx_acc(evt_rx_acc),
  .evt_mode_rxo(evt_mode_rxo)
);

// File: tb/spi_rxo_master_tb.sv
`timescale 1ns/1ps
module spi_rxo_master_tb_top;
  localparam int W = 8;
  localparam int DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_enable = 0, ctl_rxonly = 0, ctl_autoss = 1, ctl_ss = 0;
  logic ctl_txrst = 0, ctl_rxrst = 0;
  logic [7:0] ctl_div = 8'd1;
  logic tx_push = 0, rx_pop = 0;
  logic [W-1:0] tx_data = '0;
  logic tx_full, tx_empty, rx_full, rx_empty, busy, overrun;
  logic spi_sclk, spi_mosi, spi_miso, spi_ss_n;
  logic [W-1:0] rx_data;

  spi_rxo_master #(.WORD_W(W), .TX_DEPTH(4), .RX_DEPTH(4), .DIVW(8), .START_DLY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_rxonly(ctl_rxonly),
    .ctl_autoss(ctl_autoss), .ctl_ss(ctl_ss), .ctl_txrst(ctl_txrst),
    .ctl_rxrst(ctl_rxrst), .ctl_div(ctl_div), .tx_push(tx_push),
    .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_full(rx_full),
    .rx_empty(rx_empty), .busy(busy), .overrun(overrun),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Slave model and bus monitor, both sampled away from the clock edge.
  int sidx = 0, rises = 0, last_rise = 0, min_per = 0, max_per = 0;
  bit have_prev = 0, sclk_prev = 0;
  logic mlog [0:255];

  function automatic logic slave_bit(input int i);
    logic [31:0] h;
    h = i * 32'h9E37 + 32'd7;
    return h[5] ^ h[11] ^ h[2];
  endfunction

  assign spi_miso = slave_bit(sidx);

  always @(negedge clk) begin
    if (spi_sclk && !sclk_prev) begin
      mlog[rises % 256] = spi_mosi;
      rises = rises + 1;
      if (have_prev) begin
        if (cyc - last_rise < min_per) min_per = cyc - last_rise;
        if (cyc - last_rise > max_per) max_per = cyc - last_rise;
      end
      have_prev = 1;
      last_rise = cyc;
    end
    if (!spi_sclk && sclk_prev) sidx = sidx + 1;
    sclk_prev = spi_sclk;
  end

  int n_checks = 0, n_fail = 0;
  int r0 = 0, s0 = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input int base, input int j);
    logic [W-1:0] w = '0;
    for (int b = 0; b < W; b++) w = {w[W-2:0], slave_bit(base + j * W + b)};
    return w;
  endfunction

  function automatic logic [W-1:0] mosi_word(input int base, input int j);
    logic [W-1:0] w = '0;
    for (int b = 0; b < W; b++) w = {w[W-2:0], mlog[(base + j * W + b) % 256]};
    return w;
  endfunction

  task automatic mark_start();
    r0 = rises; s0 = sidx; have_prev = 0; min_per = 1000; max_per = 0;
  endtask

  task automatic at_neg_after(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(req, busy, 0);
  endtask

  task automatic push_tx(input logic [W-1:0] d);
    tx_data = d; tx_push = 1; @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_check(input string req, input logic [W-1:0] e);
    chk(req, rx_data, e);
    rx_pop = 1; @(negedge clk); rx_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 sclk", spi_sclk, 0);
    chk("R1 ss_n", spi_ss_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 fifos empty", {tx_empty, rx_empty}, 2'b11);
  endtask

  task automatic t_normal();
    ctl_div = 8'd2; ctl_autoss = 1;
    push_tx(8'h96); push_tx(8'h3A);
    mark_start();
    ctl_enable = 1; @(negedge clk); @(negedge clk);
    chk("R7 busy in transfer", busy, 1);
    chk("R7 auto ss", spi_ss_n, 0);
    wait_idle("R3 stops when tx empty");
    chk("R3 bit count", rises - r0, 16);
    chk("R2 period min", min_per, 6);
    chk("R2 period max", max_per, 6);
    chk("R3 mosi word0", mosi_word(r0, 0), 8'h96);
    chk("R3 mosi word1", mosi_word(r0, 1), 8'h3A);
    chk("R2 sclk parked", spi_sclk, 0);
    pop_check("R3 rx word0", exp_word(s0, 0));
    chk("R3 rx word1 head", rx_data, exp_word(s0, 1));
  endtask

  task automatic t_manual_ss();
    ctl_enable = 0; ctl_autoss = 0; ctl_ss = 1; @(negedge clk);
    chk("R7 manual ss on", spi_ss_n, 0);
    ctl_ss = 0; @(negedge clk);
    chk("R7 manual ss off", spi_ss_n, 1);
    ctl_autoss = 1;
  endtask

  task automatic t_txreset();
    push_tx(8'h11); push_tx(8'h22);
    chk("R12 tx loaded", tx_empty, 0);
    ctl_txrst = 1; @(negedge clk); ctl_txrst = 0;
    chk("R12 tx reset", tx_empty, 1);
  endtask

  task automatic t_entry_stop();
    int k;
    ctl_div = 8'd1;
    push_tx(8'h5A);                   // must be flushed on entry
    chk("R5 rx holds old word", rx_empty, 0);
    mark_start();
    ctl_enable = 1; ctl_rxonly = 1; k = cyc + 1;
    @(negedge clk);
    chk("R6 low at entry", spi_sclk, 0);
    chk("R7 busy at entry", busy, 1);
    chk("R7 ss at entry", spi_ss_n, 0);
    for (int j = 1; j <= DLY - 1; j++) begin
      @(negedge clk);
      chk("R6 low during delay", spi_sclk, 0);
      if (j == 1) chk("R5 both fifos flushed", {tx_empty, rx_empty}, 2'b11);
      if (j == 2) begin tx_data = 8'hC3; tx_push = 1; end
      if (j == 3) tx_push = 0;
    end
    @(negedge clk);
    chk("R6 first rise at k+6", spi_sclk, 1);
    at_neg_after(k + 80);
    chk("R7 busy mid stream", busy, 1);
    ctl_rxonly = 0;
    wait_idle("R11 busy falls");
    chk("R11 current word finished", rises - r0, 24);
    chk("R11 sclk low", spi_sclk, 0);
    chk("R11 ss released", spi_ss_n, 1);
    chk("R4 period min", min_per, 4);
    chk("R4 period max", max_per, 4);
    chk("R8 pushed word sent", mosi_word(r0, 0), 8'hC3);
    chk("R8 zeros when empty", mosi_word(r0, 1), 8'h00);
    for (int j = 0; j < 3; j++) pop_check("R4 stream word", exp_word(s0, j));
    chk("R4 rx drained", rx_empty, 1);
  endtask

  task automatic t_overrun();
    int k;
    mark_start();
    ctl_rxonly = 1; k = cyc + 1;
    at_neg_after(k + 130);
    chk("R9 full no overrun yet", {rx_full, overrun}, 2'b10);
    at_neg_after(k + 161);
    rx_pop = 1; @(negedge clk); rx_pop = 0;   // pop lands on edge k+162
    chk("R10 full after pop+push", rx_full, 1);
    chk("R10 no overrun", overrun, 0);
    at_neg_after(k + 194);
    chk("R9 overrun set", overrun, 1);
    chk("R9 clock still running", busy, 1);
    ctl_rxonly = 0;
    wait_idle("R11 stop after overrun");
    chk("R9 period max", max_per, 4);
    pop_check("R10 word1 kept", exp_word(s0, 1));
    pop_check("R10 word2 kept", exp_word(s0, 2));
    chk("R9 overrun sticky", overrun, 1);
    ctl_rxrst = 1; @(negedge clk); ctl_rxrst = 0;
    chk("R12 rx reset empties", rx_empty, 1);
    chk("R12 rx reset clears overrun", overrun, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset();
        t_normal();
        t_manual_ss();
        t_txreset();
        t_entry_stop();
        t_overrun();
      end
      begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule